// File: doc/BRIEF.md
# Raster Line Interrupt Generator

This block turns the horizontal and vertical sync outputs of a video timing controller into a regular interrupt for the host processor. It counts scan lines in a 6-bit counter that advances on every falling edge of `hsync`. Each time the count reaches 52, it fires an interrupt and restarts from zero.

During vertical sync the block re-aligns the line count to the frame. It tallies the sync line edges seen while `vsync` is high, and on the third such edge it restarts the counter. An interrupt is fired on that edge only if the count is still low enough; otherwise the counter is simply restarted. This keeps the interrupts locked to the picture, however the count stood when the frame began.

The interrupt output is a self-timed pulse of a fixed number of clock cycles. An acknowledge strobe from the processor drops the counter's top bit, which delays the next interrupt when the service routine starts late. A clear strobe from the mode register interface restarts the count.

Top module: `raster_irq_gen`

## Requirements
- R1: After reset `line_count` is 0 and `irq` is 0.
- R2: When an `hsync` falling edge brings the count to 52, `irq` is raised and `line_count` becomes 0.
- R3: A falling edge of `hsync` (high at one rising clock edge, low at the next) advances `line_count` by 1 when no other rule applies, and `irq` stays low.
- R4: Once raised, `irq` is high for exactly 22 clock cycles, starting at the clock edge that registers the triggering `hsync` edge, and then it falls by itself.
- R5: A one-cycle `irq_ack` clears bit 5 of `line_count` and leaves bits 4..0 unchanged. When bit 5 is already 0, the count does not change.
- R6: `cnt_clear` sets `line_count` to 0. It overrides an `hsync` edge in the same cycle, and that edge raises no interrupt.
- R7: While `vsync` is high, the third `hsync` falling edge sets `line_count` to 0 and raises `irq` if the incremented count is below 32.
- R8: In the same case, if the incremented count is 32 or more, `line_count` becomes 0 and `irq` is not raised.
- R9: A line with `vsync` low discards the tally of edges seen under `vsync`, so the resync needs three consecutive edges with `vsync` high.
- R10: An `irq_ack` in the same cycle as an `hsync` falling edge is ignored. The edge's increment applies and bit 5 keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also times the interrupt pulse |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync | input | 1 | Horizontal sync from the video timing controller |
| vsync | input | 1 | Vertical sync from the video timing controller |
| irq_ack | input | 1 | One-cycle interrupt acknowledge from the processor |
| cnt_clear | input | 1 | One-cycle counter restart from the mode register write |
| irq | output | 1 | Interrupt request, active high |
| line_count | output | 6 | Current line count |

## Verification
The hardest cases to reach are the frame resync outcomes. They depend on the count at the moment `vsync` opens, so the stimulus first runs a set number of plain lines to bring the count to a known value (10 for the case that fires, 40 for the silent one), then issues three lines with `vsync` high. A broken tally is exposed by splitting the `vsync` lines with one low line and checking that the resync waits for three new edges. The collision cases put `irq_ack` and `cnt_clear` in the very cycle the `hsync` edge is registered, with bit 5 set beforehand so that a lost priority shows in the count.

// File: rtl/raster_irq_gen.sv
module raster_irq_gen #(
  parameter int CNT_W        = 6,
  parameter int WRAP         = 52,
  parameter int RESYNC_LIMIT = 32,
  parameter int VS_EDGES     = 2,
  parameter int PULSE        = 22,
  parameter int ACK_BIT      = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hsync,
  input  logic             vsync,
  input  logic             irq_ack,
  input  logic             cnt_clear,
  output logic             irq,
  output logic [CNT_W-1:0] line_count
);
  localparam int PW = $clog2(PULSE + 1);
  localparam int VW = $clog2(VS_EDGES + 1);

  logic          hs_q;
  logic [VW-1:0] vs_edges;
  logic [PW-1:0] pulse_left;
  logic [CNT_W-1:0] cnt_inc;
  logic fall, resync, wrap_hit, raise;

  assign fall     = hs_q && !hsync;
  assign cnt_inc  = line_count + CNT_W'(1);
  assign resync   = fall && vsync && (vs_edges >= VW'(VS_EDGES));
  assign wrap_hit = fall && !resync && (cnt_inc == CNT_W'(WRAP));
  assign raise    = !cnt_clear &&
                    ((resync && (cnt_inc < CNT_W'(RESYNC_LIMIT))) || wrap_hit);
  assign irq      = (pulse_left != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_q       <= 1'b0;
      vs_edges   <= '0;
      line_count <= '0;
      pulse_left <= '0;
    end else begin
      hs_q <= hsync;

      if (!vsync)      vs_edges <= '0;
      else if (resync) vs_edges <= '0;
      else if (fall)   vs_edges <= vs_edges + VW'(1);

      if (cnt_clear)                line_count <= '0;
      else if (resync || wrap_hit)  line_count <= '0;
      else if (fall)                line_count <= cnt_inc;
      else if (irq_ack)             line_count <= line_count & ~(CNT_W'(1) << ACK_BIT);

      if (raise)           pulse_left <= PW'(PULSE);
      else if (irq)        pulse_left <= pulse_left - PW'(1);
    end
  end

  a_r2_below_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    line_count < CNT_W'(WRAP));

  a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clear |=> (line_count == '0));

  a_r5_ack_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !fall && !cnt_clear) |=>
      (!line_count[ACK_BIT] && line_count[ACK_BIT-1:0] == $past(line_count[ACK_BIT-1:0])));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall && !irq_ack && !cnt_clear) |=> $stable(line_count));

  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && !vsync && !cnt_clear) |=>
      ((line_count == $past(line_count) + CNT_W'(1)) || (line_count == '0 && irq)));

  a_r4_rise_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(fall));
endmodule

// File: tb/sim_raster_irq_gen.sv
module sim_raster_irq_gen;
  logic clk = 1'b0, rst_n = 1'b0;
  logic hsync = 1'b0, vsync = 1'b0, irq_ack = 1'b0, cnt_clear = 1'b0;
  logic irq;
  logic [5:0] line_count;

  raster_irq_gen u0 (.clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
                     .irq_ack(irq_ack), .cnt_clear(cnt_clear), .irq(irq),
                     .line_count(line_count));

  always #10 clk = ~clk;

  typedef struct { string req; int cnt; bit irq; } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0;
  int m_cnt = 0, m_vs = 0;
  bit done = 0;

  task automatic chk(input string req, input int got, input int want);
    checks++;
    if (got != want) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, want);
    end
  endtask

  always @(negedge clk)
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk({e.req, " count"}, int'(line_count), e.cnt);
      chk({e.req, " irq"}, int'(irq), int'(e.irq));
    end

  task automatic push(input string req, input bit ix);
    exp_t e;
    e.req = req; e.cnt = m_cnt; e.irq = ix;
    q.push_back(e);
  endtask

  task automatic hline(input string req, input bit vs, input bit ack, input bit clr);
    bit res = 0, ix = 0;
    @(negedge clk); vsync = vs; hsync = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk); hsync = 1'b0; irq_ack = ack; cnt_clear = clr;
    @(posedge clk); #1;
    if (vs) begin
      if (m_vs >= 2) begin res = 1; m_vs = 0; end else m_vs++;
    end else m_vs = 0;
    if (clr) m_cnt = 0;
    else if (res) begin ix = (m_cnt + 1) < 32; m_cnt = 0; end
    else if (m_cnt + 1 == 52) begin ix = 1; m_cnt = 0; end
    else m_cnt++;
    push(req, ix);
    @(negedge clk); irq_ack = 1'b0; cnt_clear = 1'b0;
    repeat (24) @(posedge clk);
  endtask

  task automatic strobe(input string req, input bit ack);
    @(negedge clk); irq_ack = ack; cnt_clear = !ack;
    @(posedge clk); #1;
    if (ack) m_cnt = m_cnt & ~32; else m_cnt = 0;
    push(req, 1'b0);
    @(negedge clk); irq_ack = 1'b0; cnt_clear = 1'b0;
    repeat (2) @(posedge clk);
  endtask

  task automatic lines_to(input string req, input int target);
    while (m_cnt != target) hline(req, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 count", int'(line_count), 0);
    chk("R1 irq", int'(irq), 0);
    rst_n = 1'b1;

    for (int i = 0; i < 51; i++) hline("R3", 1'b0, 1'b0, 1'b0);
    @(negedge clk); vsync = 1'b0; hsync = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk); hsync = 1'b0;
    @(posedge clk); #1;
    m_cnt = 0;
    push("R2", 1'b1);
    begin
      int n = 0;
      while (irq && n < 100) begin @(posedge clk); #1; n++; end
      chk("R4 pulse width", n, 22);
    end
    repeat (4) @(posedge clk);

    lines_to("R3", 40);
    strobe("R5 ack bit5 set", 1'b1);
    strobe("R5 ack bit5 clear", 1'b1);

    strobe("R6 clear strobe", 1'b0);
    lines_to("R3", 5);
    hline("R6 clear beats edge", 1'b0, 1'b0, 1'b1);

    lines_to("R3", 10);
    hline("R7 vs edge1", 1'b1, 1'b0, 1'b0);
    hline("R7 vs edge2", 1'b1, 1'b0, 1'b0);
    hline("R7 resync fires", 1'b1, 1'b0, 1'b0);
    hline("R3", 1'b0, 1'b0, 1'b0);

    lines_to("R3", 40);
    hline("R8 vs edge1", 1'b1, 1'b0, 1'b0);
    hline("R8 vs edge2", 1'b1, 1'b0, 1'b0);
    hline("R8 resync silent", 1'b1, 1'b0, 1'b0);
    hline("R3", 1'b0, 1'b0, 1'b0);

    hline("R9 vs a1", 1'b1, 1'b0, 1'b0);
    hline("R9 vs a2", 1'b1, 1'b0, 1'b0);
    hline("R9 gap", 1'b0, 1'b0, 1'b0);
    hline("R9 vs b1", 1'b1, 1'b0, 1'b0);
    hline("R9 vs b2", 1'b1, 1'b0, 1'b0);
    hline("R9 vs b3 resync", 1'b1, 1'b0, 1'b0);
    hline("R3", 1'b0, 1'b0, 1'b0);

    lines_to("R3", 33);
    hline("R10 ack with edge", 1'b0, 1'b1, 1'b0);
    chk("R10 bit5 kept", m_cnt, 34);

    repeat (4) @(posedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule